// File: doc/BRIEF.md
# Eight-Bit ALU with Masked Status Update

This block is an 8-bit arithmetic and logic unit. Its result path is purely combinational, and it keeps a registered status word. A decoder selects one of twenty-one operations on two byte operands: bitwise logic, complements, add and subtract (with or without carry), compare, increment and decrement, shifts and rotates, nibble swap, and moving a single bit into or out of the T bit.

The status word is updated on a clock edge, and only when `exec_en` is high. Each operation writes a fixed subset of the flags and leaves every other flag as it was. The stored C bit is the incoming carry for the with-carry forms.

Subtract-with-carry and compare-with-carry can only clear Z, never set it. A chain of byte operations therefore reports equality only when every byte matched.

Top module: `alu8_core`

## Requirements
- R1: `status` bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, and bit 7 always reads 0. While `rst` is high on a clock edge, the whole word is cleared to 0.
- R2: Opcodes on `op_sel` are AND=0, OR=1, XOR=2, COM=3, NEG=4, ADD=5, ADC=6, SUB=7, SBC=8, CP=9, CPC=10, INC=11, DEC=12, ASR=13, LSL=14, LSR=15, ROL=16, ROR=17, SWAP=18, TSTORE=19, TLOAD=20. `result` follows the inputs with no clock delay. `status` changes only on a rising edge with `exec_en` high; with `exec_en` low it holds.
- R3: AND, OR and XOR return the bitwise result of `opa` and `opb`. They set Z and N from the result and clear V. They leave C, H and T unchanged.
- R4: COM returns 0xFF minus `opa`. It sets C to 1, clears V, and sets Z and N from the result. H and T are unchanged.
- R5: NEG returns 0 minus `opa`. C is 1 when the result is nonzero. V is 1 when the result is 0x80. H is 1 when `opa[3:0]` is nonzero. Z and N follow the result.
- R6: ADD returns `opa`+`opb`, and ADC also adds the stored C. C is the carry out of bit 7 and H the carry out of bit 3. V is signed overflow. Z and N follow the result.
- R7: SUB returns `opa`-`opb`, and SBC also subtracts the stored C. C is the borrow out of bit 7 and H the borrow into bit 4. V is signed overflow and N follows the result. For SUB, Z is 1 when the result is zero. For SBC, Z is cleared on a nonzero result and otherwise keeps its old value.
- R8: CP and CPC set the flags exactly as SUB and SBC would, including the Z chaining of CPC, but `result` equals `opa`.
- R9: INC and DEC return `opa`+1 and `opa`-1 modulo 256. V is 1 exactly when `opa` was 0x7F (INC) or 0x80 (DEC). Z and N follow the result. C, H and T are unchanged.
- R10: ASR keeps bit 7, LSR inserts 0 at bit 7, LSL inserts 0 at bit 0, ROL inserts the old C at bit 0, and ROR inserts the old C at bit 7. C takes the bit shifted out and V becomes N xor C. Z and N follow the result, and H and T are unchanged.
- R11: SWAP returns `{opa[3:0], opa[7:4]}` and changes no flag.
- R12: TSTORE copies `opa[bit_sel]` into T and changes no other flag, with `result`=`opa`. TLOAD returns `opa` with bit `bit_sel` replaced by T and changes no flag.
- R13: S is N xor V after every update.
- R14: Opcodes 21 to 31 return `opa` and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Commit this cycle's flag update |
| op_sel | input | 5 | Operation code |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| bit_sel | input | 3 | Bit index for TSTORE and TLOAD |
| result | output | 8 | Combinational result |
| status | output | 8 | Registered status word |

## Verification
The following rules are checked on every cycle:
- S always equals N xor V.
- An idle cycle, SWAP, TLOAD or an unassigned code leaves the status word unchanged.
- INC and DEC never touch C.
- The logic operations clear V.
- SBC and CPC never raise Z.
- Compares leave the operand on `result`.

The arithmetic values themselves need the bench's reference model and its scenarios: carry and half-carry edges, overflow at 0x7F and 0x80, rotates through a set carry, and multi-byte compare chains in which an early mismatch must keep Z low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int NIB   = DW / 2;
    localparam int BSW   = $clog2(DW);
    localparam int OPW   = 5;

    typedef enum logic [OPW-1:0] {
        OP_AND   = 5'd0,
        OP_OR    = 5'd1,
        OP_XOR   = 5'd2,
        OP_COM   = 5'd3,
        OP_NEG   = 5'd4,
        OP_ADD   = 5'd5,
        OP_ADC   = 5'd6,
        OP_SUB   = 5'd7,
        OP_SBC   = 5'd8,
        OP_CP    = 5'd9,
        OP_CPC   = 5'd10,
        OP_INC   = 5'd11,
        OP_DEC   = 5'd12,
        OP_ASR   = 5'd13,
        OP_LSL   = 5'd14,
        OP_LSR   = 5'd15,
        OP_ROL   = 5'd16,
        OP_ROR   = 5'd17,
        OP_SWAP  = 5'd18,
        OP_TSTO  = 5'd19,
        OP_TLOD  = 5'd20
    } alu_op_e;

    // Packed order gives C at bit 0 up to the reserved bit at bit 7.
    typedef struct packed {
        logic rsv;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } stat_t;

    localparam stat_t M_NONE  = '{rsv:1'b0, t:1'b0, h:1'b0, s:1'b0, v:1'b0, n:1'b0, z:1'b0, c:1'b0};
    localparam stat_t M_ZNV   = '{rsv:1'b0, t:1'b0, h:1'b0, s:1'b1, v:1'b1, n:1'b1, z:1'b1, c:1'b0};
    localparam stat_t M_ZCNV  = '{rsv:1'b0, t:1'b0, h:1'b0, s:1'b1, v:1'b1, n:1'b1, z:1'b1, c:1'b1};
    localparam stat_t M_ARITH = '{rsv:1'b0, t:1'b0, h:1'b1, s:1'b1, v:1'b1, n:1'b1, z:1'b1, c:1'b1};
    localparam stat_t M_TBIT  = '{rsv:1'b0, t:1'b1, h:1'b0, s:1'b0, v:1'b0, n:1'b0, z:1'b0, c:1'b0};

    function automatic logic is_shift(alu_op_e op);
        return (op == OP_ASR) || (op == OP_LSL) || (op == OP_LSR) ||
               (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic is_chained(alu_op_e op);
        return (op == OP_SBC) || (op == OP_CPC);
    endfunction

    function automatic logic [DW-1:0] one_hot_bit(logic [BSW-1:0] idx);
        logic [DW-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          hout,
    output logic          vout
);
    logic [DW:0]  full;
    logic [NIB:0] low;
    logic [DW:0]  cin_w;
    logic [NIB:0] cin_n;

    assign cin_w = {{DW{1'b0}}, cin};
    assign cin_n = {{NIB{1'b0}}, cin};

    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - cin_w;
            low  = {1'b0, x[NIB-1:0]} - {1'b0, y[NIB-1:0]} - cin_n;
        end else begin
            full = {1'b0, x} + {1'b0, y} + cin_w;
            low  = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + cin_n;
        end
        res  = full[DW-1:0];
        cout = full[DW];
        hout = low[NIB];
        if (sub)
            vout = (x[DW-1] & ~y[DW-1] & ~res[DW-1]) | (~x[DW-1] & y[DW-1] & res[DW-1]);
        else
            vout = (x[DW-1] & y[DW-1] & ~res[DW-1]) | (~x[DW-1] & ~y[DW-1] & res[DW-1]);
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           cin,
    input  logic           tin,
    input  logic [BSW-1:0] bsel,
    output logic [DW-1:0]  res,
    output logic           cout
);
    logic [DW-1:0] sel_mask;

    assign sel_mask = one_hot_bit(bsel);

    always_comb begin
        res  = a;
        cout = cin;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_ASR:  begin res = {a[DW-1], a[DW-1:1]}; cout = a[0];    end
            OP_LSR:  begin res = {1'b0,    a[DW-1:1]}; cout = a[0];    end
            OP_LSL:  begin res = {a[DW-2:0], 1'b0};    cout = a[DW-1]; end
            OP_ROL:  begin res = {a[DW-2:0], cin};     cout = a[DW-1]; end
            OP_ROR:  begin res = {cin, a[DW-1:1]};     cout = a[0];    end
            OP_SWAP: res = {a[NIB-1:0], a[DW-1:NIB]};
            OP_TLOD: res = tin ? (a | sel_mask) : (a & ~sel_mask);
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  stat_t nxt,
    input  stat_t mask,
    output stat_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= (q & ~mask) | (nxt & mask);
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   exec_en,
    input  logic [OPW-1:0]         op_sel,
    input  logic [DW-1:0]          opa,
    input  logic [DW-1:0]          opb,
    input  logic [BSW-1:0]         bit_sel,
    output logic [DW-1:0]          result,
    output logic [DW-1:0]          status
);
    alu_op_e       op;
    stat_t         st_q;
    stat_t         st_nxt;
    stat_t         st_mask;

    logic [DW-1:0] as_x, as_y, as_res;
    logic          as_cin, as_sub, as_c, as_h, as_v;
    logic [DW-1:0] bo_res;
    logic          bo_c;
    logic [DW-1:0] flag_src;

    assign op = alu_op_e'(op_sel);

    alu8_addsub u_addsub (
        .x    (as_x),
        .y    (as_y),
        .cin  (as_cin),
        .sub  (as_sub),
        .res  (as_res),
        .cout (as_c),
        .hout (as_h),
        .vout (as_v)
    );

    alu8_bitops u_bitops (
        .op   (op),
        .a    (opa),
        .b    (opb),
        .cin  (st_q.c),
        .tin  (st_q.t),
        .bsel (bit_sel),
        .res  (bo_res),
        .cout (bo_c)
    );

    always_comb begin
        as_x     = opa;
        as_y     = opb;
        as_cin   = 1'b0;
        as_sub   = 1'b0;
        result   = opa;
        flag_src = opa;
        st_nxt   = '0;
        st_mask  = M_NONE;

        unique case (op)
            OP_AND, OP_OR, OP_XOR: begin
                result   = bo_res;
                flag_src = bo_res;
                st_mask  = M_ZNV;
            end
            OP_COM: begin
                result   = bo_res;
                flag_src = bo_res;
                st_nxt.c = 1'b1;
                st_mask  = M_ZCNV;
            end
            OP_NEG: begin
                as_x     = '0;
                as_y     = opa;
                as_sub   = 1'b1;
                result   = as_res;
                flag_src = as_res;
                st_nxt.c = as_c;
                st_nxt.h = as_h;
                st_nxt.v = as_v;
                st_mask  = M_ARITH;
            end
            OP_ADD, OP_ADC: begin
                as_cin   = (op == OP_ADC) & st_q.c;
                result   = as_res;
                flag_src = as_res;
                st_nxt.c = as_c;
                st_nxt.h = as_h;
                st_nxt.v = as_v;
                st_mask  = M_ARITH;
            end
            OP_SUB, OP_SBC, OP_CP, OP_CPC: begin
                as_sub   = 1'b1;
                as_cin   = is_chained(op) & st_q.c;
                result   = ((op == OP_CP) || (op == OP_CPC)) ? opa : as_res;
                flag_src = as_res;
                st_nxt.c = as_c;
                st_nxt.h = as_h;
                st_nxt.v = as_v;
                st_mask  = M_ARITH;
            end
            OP_INC, OP_DEC: begin
                as_y     = {{(DW-1){1'b0}}, 1'b1};
                as_sub   = (op == OP_DEC);
                result   = as_res;
                flag_src = as_res;
                st_nxt.v = as_v;
                st_mask  = M_ZNV;
            end
            OP_ASR, OP_LSL, OP_LSR, OP_ROL, OP_ROR: begin
                result   = bo_res;
                flag_src = bo_res;
                st_nxt.c = bo_c;
                st_mask  = M_ZCNV;
            end
            OP_SWAP, OP_TLOD: begin
                result   = bo_res;
            end
            OP_TSTO: begin
                st_nxt.t = opa[bit_sel];
                st_mask  = M_TBIT;
            end
            default: begin
                result   = opa;
            end
        endcase

        st_nxt.z = ~|flag_src;
        if (is_chained(op))
            st_nxt.z = st_nxt.z & st_q.z;
        st_nxt.n = flag_src[DW-1];
        if (is_shift(op))
            st_nxt.v = st_nxt.n ^ st_nxt.c;
        st_nxt.s = st_nxt.n ^ st_nxt.v;
    end

    alu8_status u_status (
        .clk  (clk),
        .rst  (rst),
        .load (exec_en),
        .nxt  (st_nxt),
        .mask (st_mask),
        .q    (st_q)
    );

    assign status = st_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       exec_en,
    input logic [4:0] op_sel,
    input logic [7:0] opa,
    input logic [7:0] result,
    input logic [7:0] status
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[7] == 1'b0);                                                   // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(status));                                        // R2

    AST_LOGIC_CLEARS_V: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel <= 5'd2) |=> (status[3] == 1'b0 && status[0] == $past(status[0]) && status[5] == $past(status[5]))); // R3

    AST_CHAIN_Z_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (op_sel == 5'd8 || op_sel == 5'd10) && !status[1]) |=> !status[1]); // R7

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 5'd9 || op_sel == 5'd10) |-> result == opa);              // R8

    AST_STEP_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (op_sel == 5'd11 || op_sel == 5'd12)) |=> status[0] == $past(status[0])); // R9

    AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel == 5'd18) |=> $stable(status));                   // R11

    AST_SWAP_RESULT: assert property (@(posedge clk) disable iff (rst)
        op_sel == 5'd18 |-> result == {opa[3:0], opa[7:4]});                 // R11

    AST_TLOAD_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel == 5'd20) |=> $stable(status));                   // R12

    AST_SIGN_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
        status[4] == (status[2] ^ status[3]));                               // R13

    AST_UNUSED_OP_INERT: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel >= 5'd21) |=> $stable(status));                   // R14
endmodule

bind alu8_core alu8_core_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .exec_en (exec_en),
    .op_sel  (op_sel),
    .opa     (opa),
    .result  (result),
    .status  (status)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
    logic       clk;
    logic       rst;
    logic       exec_en;
    logic [4:0] op_sel;
    logic [7:0] opa;
    logic [7:0] opb;
    logic [2:0] bit_sel;
    logic [7:0] result;
    logic [7:0] status;

    int checks;
    int fails;
    bit done;

    // Reference flag state
    bit mc, mz, mn, mv, ms, mh, mt;

    alu8_core dut_i (
        .clk     (clk),
        .rst     (rst),
        .exec_en (exec_en),
        .op_sel  (op_sel),
        .opa     (opa),
        .opb     (opb),
        .bit_sel (bit_sel),
        .result  (result),
        .status  (status)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic string tag_of(int op);
        case (op)
            0, 1, 2:            return "R3";
            3:                  return "R4";
            4:                  return "R5";
            5, 6:               return "R6";
            7, 8:               return "R7";
            9, 10:              return "R8";
            11, 12:             return "R9";
            13, 14, 15, 16, 17: return "R10";
            18:                 return "R11";
            19, 20:             return "R12";
            default:            return "R14";
        endcase
    endfunction

    function automatic int sgn(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic bit [7:0] model_status();
        return {1'b0, mt, mh, ms, mv, mn, mz, mc};
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: returns the result and, if commit, updates flags.
    task automatic model(input int op, input int a, input int b, input int bs,
                         input bit commit, output int r);
        int  d, full, lo;
        bit  c, z, n, v, h, t;
        bit  wz, wc, wv, wh, wt;
        bit  chain;
        c = mc; z = mz; n = mn; v = mv; h = mh; t = mt;
        wz = 0; wc = 0; wv = 0; wh = 0; wt = 0; chain = 0;
        r = a;
        d = a;
        case (op)
            0, 1, 2: begin
                r = (op == 0) ? (a & b) : (op == 1) ? (a | b) : (a ^ b);
                d = r; v = 0; wz = 1; wv = 1;
            end
            3: begin r = 255 - a; d = r; c = 1; v = 0; wz = 1; wc = 1; wv = 1; end
            4: begin
                full = 0 - a; r = full & 255; d = r;
                c = (full < 0); h = ((0 - (a % 16)) < 0);
                v = ((0 - sgn(a)) > 127) || ((0 - sgn(a)) < -128);
                wz = 1; wc = 1; wv = 1; wh = 1;
            end
            5, 6: begin
                full = a + b + ((op == 6) ? int'(mc) : 0);
                r = full & 255; d = r;
                c = (full > 255);
                h = ((a % 16) + (b % 16) + ((op == 6) ? int'(mc) : 0)) > 15;
                lo = sgn(a) + sgn(b) + ((op == 6) ? int'(mc) : 0);
                v = (lo > 127) || (lo < -128);
                wz = 1; wc = 1; wv = 1; wh = 1;
            end
            7, 8, 9, 10: begin
                chain = (op == 8) || (op == 10);
                full = a - b - (chain ? int'(mc) : 0);
                d = full & 255;
                r = (op >= 9) ? a : d;
                c = (full < 0);
                h = ((a % 16) - (b % 16) - (chain ? int'(mc) : 0)) < 0;
                lo = sgn(a) - sgn(b) - (chain ? int'(mc) : 0);
                v = (lo > 127) || (lo < -128);
                wz = 1; wc = 1; wv = 1; wh = 1;
            end
            11: begin r = (a + 1) % 256; d = r; v = (a == 127); wz = 1; wv = 1; end
            12: begin r = (a + 255) % 256; d = r; v = (a == 128); wz = 1; wv = 1; end
            13, 14, 15, 16, 17: begin
                case (op)
                    13: begin r = (a / 2) + (a & 128);     c = a % 2;  end
                    14: begin r = (a * 2) % 256;           c = a / 128; end
                    15: begin r = a / 2;                   c = a % 2;  end
                    16: begin r = (a * 2) % 256 + int'(mc); c = a / 128; end
                    default: begin r = a / 2 + 128 * int'(mc); c = a % 2; end
                endcase
                d = r; wz = 1; wc = 1; wv = 1;
            end
            18: r = (a % 16) * 16 + a / 16;
            19: begin t = ((a >> bs) & 1) != 0; wt = 1; end
            20: r = mt ? (a | (1 << bs)) : (a & ~(1 << bs) & 255);
            default: r = a;
        endcase
        if (wz) begin
            n = (d >= 128);
            if (op >= 13 && op <= 17) v = n ^ c;
            if (chain) z = (d == 0) && mz;
            else       z = (d == 0);
        end
        if (commit) begin
            if (wz) begin mz = z; mn = n; ms = n ^ v; end
            if (wv) mv = v;
            if (wc) mc = c;
            if (wh) mh = h;
            if (wt) mt = t;
        end
    endtask

    // One cycle: check status from the previous edge, drive, check result.
    task automatic step(bit en, int op, int a, int b, int bs);
        int r;
        @(negedge clk);
        check((op >= 21) ? "R14" : tag_of(op), int'(status), int'(model_status()), "status before op");
        check("R13", int'(status[4]), int'(status[2] ^ status[3]), "S vs N^V");
        exec_en = en;
        op_sel  = op[4:0];
        opa     = a[7:0];
        opb     = b[7:0];
        bit_sel = bs[2:0];
        #1;
        model(op, a, b, bs, en, r);
        check(tag_of(op), int'(result), r, $sformatf("result op %0d", op));
        if (!en) begin
            @(negedge clk);
            check("R2", int'(status), int'(model_status()), "idle cycle held status");
            exec_en = 1'b0;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        checks = 0; fails = 0; done = 0;
        {mc, mz, mn, mv, ms, mh, mt} = '0;
        rst = 1'b1; exec_en = 1'b1; op_sel = 5'd5; opa = 8'hFF; opb = 8'h01; bit_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; exec_en = 1'b0;
        @(negedge clk);
        check("R1", int'(status), 0, "reset status");

        // R6 carry and half carry, then ADC folding C
        step(1, 5, 8'hFF, 8'h01, 0);
        step(1, 6, 8'h10, 8'h20, 0);
        step(1, 5, 8'h7F, 8'h01, 0);
        step(1, 5, 8'h0F, 8'h01, 0);
        // R7 borrow and half borrow
        step(1, 7, 8'h10, 8'h01, 0);
        step(1, 7, 8'h00, 8'h01, 0);
        step(1, 8, 8'h05, 8'h04, 0);
        step(1, 7, 8'h80, 8'h01, 0);
        // R8 chained compare: equal, equal, mismatch, equal stays low
        step(1, 9, 8'h34, 8'h34, 0);
        step(1, 10, 8'h12, 8'h12, 0);
        step(1, 10, 8'h12, 8'h13, 0);
        step(1, 10, 8'h12, 8'h12, 0);
        step(1, 7, 8'h00, 8'h01, 0);
        step(1, 8, 8'h01, 8'h00, 0);
        // R5 negate corners
        step(1, 4, 8'h80, 0, 0);
        step(1, 4, 8'h00, 0, 0);
        step(1, 4, 8'h10, 0, 0);
        // R9 step corners with C set beforehand
        step(1, 3, 8'h00, 0, 0);
        step(1, 11, 8'h7F, 0, 0);
        step(1, 11, 8'hFF, 0, 0);
        step(1, 12, 8'h80, 0, 0);
        step(1, 12, 8'h00, 0, 0);
        // R3 logic ops clear V
        step(1, 5, 8'h7F, 8'h01, 0);
        step(1, 0, 8'hF0, 8'h0F, 0);
        step(1, 1, 8'h80, 8'h01, 0);
        step(1, 2, 8'hAA, 8'hAA, 0);
        // R10 shifts and rotates through a set carry
        step(1, 3, 8'h55, 0, 0);
        step(1, 16, 8'h80, 0, 0);
        step(1, 17, 8'h01, 0, 0);
        step(1, 13, 8'h81, 0, 0);
        step(1, 14, 8'hC0, 0, 0);
        step(1, 15, 8'h01, 0, 0);
        // R11 swap, R12 T store and load
        step(1, 18, 8'hA5, 0, 0);
        step(1, 19, 8'h08, 0, 3);
        step(1, 20, 8'h00, 0, 6);
        step(1, 19, 8'hF7, 0, 3);
        step(1, 20, 8'hFF, 0, 0);
        // R14 unassigned code, R2 idle cycle
        step(1, 25, 8'h3C, 8'h11, 0);
        step(0, 5, 8'hFF, 8'hFF, 0);

        for (int i = 0; i < 3000; i++) begin
            step(($urandom_range(0, 9) != 0), $urandom_range(0, 31),
                 $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 7));
        end
        @(negedge clk);
        check("R2", int'(status), int'(model_status()), "final status");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule